// File: doc/BRIEF.md
# System Control Fault and Configuration Register Bank

This block is the part of a microcontroller's system control space that holds the configuration-control word, the three sticky fault-status words, the two fault-address words and the software interrupt trigger. The core reaches it through a 32-bit register port. The port carries a 12-bit byte offset, a write strobe and a privilege flag. Reads are combinational from the stored state.

The core reports faults as single-cycle pulses. Two named pulses mark an undefined instruction and a missing coprocessor, and three set vectors carry any other fault bit. A fault bit stays set until software writes a one to it. A write to the trigger word produces a one-cycle request for the interrupt controller, carrying the interrupt number. Such a write counts only if the number is implemented and the writer is privileged, or if the configuration word allows unprivileged triggering. The undefined-instruction and missing-coprocessor pulses also raise a one-cycle usage-fault request.

Top module: `scs_fault_regs`

## Requirements
- R1: The configuration word at offset 0xD14 stores only bits 0, 1, 3, 4, 8 and 9 of a write (mask 0x0000031B). Every other bit always reads as zero.
- R2: After reset, the configuration word reads 0x00000200 (bit 9 set). All three fault-status words and both fault-address words read zero, and `swi_valid` and `usage_pend` are low.
- R3: The fault-status words are at 0xD28 (configurable), 0xD2C (hard) and 0xD30 (debug). Writing a one to a bit clears that bit. Writing a zero leaves the bit unchanged.
- R4: Each bit of `cfs_set`, `hfs_set` or `dfs_set` that is high at a clock edge sets the same bit of its fault word. The new value is visible on a read in the next cycle.
- R5: If a hardware set and a software write-one-to-clear hit the same bit on the same edge, the bit ends up set. Other bits in the same write still clear.
- R6: The fault-address words at 0xD34 (memory-manage) and 0xD38 (bus) are plain 32-bit read/write storage.
- R7: A write to 0xF00 requests interrupt `wdata[8:0]`, but only if that number is below NUM_IRQ and either `bus_priv` is high or configuration bit 1 is set. An accepted request drives `swi_valid` high for exactly the cycle after the write, with `swi_num` equal to the number. A rejected write leaves `swi_valid` low.
- R8: An `ev_undef` pulse sets configurable fault bit 16 and an `ev_nocp` pulse sets bit 19. Either pulse drives `usage_pend` high for the following cycle.
- R9: The auxiliary word at 0xD3C, the trigger word at 0xF00 and every other offset (including offsets that are not word-aligned) read as zero. Writes to 0xD3C and to any unmapped offset change no state.
- R10: Every stored word changes only on a write to its own offset or, for the fault-status words, on a hardware set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_off | input | 12 | Byte offset in the system control space |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | High when the access is privileged |
| bus_rdata | output | 32 | Read data for `bus_off`, combinational |
| ev_undef | input | 1 | Undefined-instruction fault pulse |
| ev_nocp | input | 1 | Missing-coprocessor fault pulse |
| cfs_set | input | 32 | Hardware set vector, configurable fault status |
| hfs_set | input | 32 | Hardware set vector, hard fault status |
| dfs_set | input | 32 | Hardware set vector, debug fault status |
| swi_valid | output | 1 | One-cycle software interrupt request |
| swi_num | output | 9 | Requested interrupt number |
| usage_pend | output | 1 | One-cycle usage-fault pending request |

## Verification
A wrong mask or a wrong write-one-to-clear term shows up on the read port in the cycle right after the write. This is why every bit of every word is swept singly and read back at once. A wrong trigger gate shows up as a missing or extra `swi_valid` pulse one cycle after the write. The whole 512-value number field is therefore driven under all four privilege and enable combinations, around the NUM_IRQ boundary. A lost set-over-clear priority shows up as a fault bit that reads zero after a same-cycle collision. An offset decode fault shows up as non-zero read data, or as a changed neighbour word, after writes to the reserved offsets.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int DW      = 32;
  localparam int OFF_W   = 12;
  localparam int SWI_W   = 9;
  localparam int NFAULT  = 3;

  localparam logic [OFF_W-1:0] OFF_CCR = 12'hD14;
  localparam logic [OFF_W-1:0] OFF_CFS = 12'hD28;
  localparam logic [OFF_W-1:0] OFF_HFS = 12'hD2C;
  localparam logic [OFF_W-1:0] OFF_DFS = 12'hD30;
  localparam logic [OFF_W-1:0] OFF_MMA = 12'hD34;
  localparam logic [OFF_W-1:0] OFF_BFA = 12'hD38;
  localparam logic [OFF_W-1:0] OFF_AUX = 12'hD3C;
  localparam logic [OFF_W-1:0] OFF_SWI = 12'hF00;

  localparam logic [DW-1:0] CCR_WMASK = 32'h0000_031B;
  localparam logic [DW-1:0] CCR_RESET = 32'h0000_0200;
  localparam int CCR_USERPEND_BIT = 1;
  localparam int CFS_UNDEF_BIT    = 16;
  localparam int CFS_NOCP_BIT     = 19;

  // keep only the implemented configuration bits
  function automatic logic [DW-1:0] ccr_filter(input logic [DW-1:0] d);
    return d & CCR_WMASK;
  endfunction

  // sticky fault word update: clear-by-one first, hardware set wins
  function automatic logic [DW-1:0] w1c_next(input logic [DW-1:0] q,
                                             input logic [DW-1:0] clr,
                                             input logic [DW-1:0] set);
    return (q & ~clr) | set;
  endfunction

  // software trigger acceptance
  function automatic logic swi_allowed(input logic [SWI_W-1:0] num,
                                       input int num_irq,
                                       input logic priv,
                                       input logic user_ok);
    return (int'({23'd0, num}) < num_irq) && (priv || user_ok);
  endfunction
endpackage

// File: rtl/scs_ccr_reg.sv
module scs_ccr_reg
  import scs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= CCR_RESET;
    else if (wr_hit) q <= ccr_filter(wdata);
  end

  // R10: no write, no change
  assert_ccr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q));
endmodule

// File: rtl/scs_w1c_bank.sv
module scs_w1c_bank
  import scs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set,
  output logic [DW-1:0] q
);
  logic [DW-1:0] clr_vec;
  assign clr_vec = wr_hit ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= w1c_next(q, clr_vec, set);
  end

  // R3: with no set pending, every written one is gone next cycle
  assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && set == '0) |=> ((q & $past(wdata)) == '0));
  // R5 / R4: a set bit is always present next cycle
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
  // R10: idle cycles keep the word
  assert_w1c_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && set == '0) |=> $stable(q));
endmodule

// File: rtl/scs_swi_gate.sv
module scs_swi_gate
  import scs_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [SWI_W-1:0] num_in,
  input  logic             priv,
  input  logic             user_ok,
  output logic             swi_valid,
  output logic [SWI_W-1:0] swi_num
);
  logic accept;
  assign accept = wr_hit && swi_allowed(num_in, NUM_IRQ, priv, user_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_valid <= 1'b0;
      swi_num   <= '0;
    end else begin
      swi_valid <= accept;
      if (accept) swi_num <= num_in;
    end
  end

  assert_swi_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swi_valid |-> (int'({23'd0, swi_num}) < NUM_IRQ));
  assert_swi_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swi_valid |-> $past(wr_hit));
  assert_swi_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !priv && !user_ok) |=> !swi_valid);
endmodule

// File: rtl/scs_fault_regs.sv
module scs_fault_regs
  import scs_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [OFF_W-1:0] bus_off,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_priv,
  output logic [DW-1:0]    bus_rdata,
  input  logic             ev_undef,
  input  logic             ev_nocp,
  input  logic [DW-1:0]    cfs_set,
  input  logic [DW-1:0]    hfs_set,
  input  logic [DW-1:0]    dfs_set,
  output logic             swi_valid,
  output logic [SWI_W-1:0] swi_num,
  output logic             usage_pend
);
  localparam logic [OFF_W-1:0] FAULT_OFF [NFAULT] = '{OFF_CFS, OFF_HFS, OFF_DFS};

  // named internal events
  logic ccr_wr, mma_wr, bfa_wr, swi_wr, usage_evt;
  logic [DW-1:0] ccr_q, mma_q, bfa_q;
  logic [DW-1:0] fault_set [NFAULT];
  logic [DW-1:0] fault_q   [NFAULT];
  logic [NFAULT-1:0] fault_wr;
  logic [DW-1:0] ev_vec;

  assign ccr_wr    = bus_wr && (bus_off == OFF_CCR);
  assign mma_wr    = bus_wr && (bus_off == OFF_MMA);
  assign bfa_wr    = bus_wr && (bus_off == OFF_BFA);
  assign swi_wr    = bus_wr && (bus_off == OFF_SWI);
  assign usage_evt = ev_undef || ev_nocp;

  always_comb begin
    ev_vec = '0;
    ev_vec[CFS_UNDEF_BIT] = ev_undef;
    ev_vec[CFS_NOCP_BIT]  = ev_nocp;
  end

  assign fault_set[0] = cfs_set | ev_vec;
  assign fault_set[1] = hfs_set;
  assign fault_set[2] = dfs_set;

  scs_ccr_reg u_ccr (
    .clk(clk), .rst_n(rst_n), .wr_hit(ccr_wr), .wdata(bus_wdata), .q(ccr_q)
  );

  for (genvar g = 0; g < NFAULT; g++) begin : g_fault
    assign fault_wr[g] = bus_wr && (bus_off == FAULT_OFF[g]);
    scs_w1c_bank u_bank (
      .clk(clk), .rst_n(rst_n), .wr_hit(fault_wr[g]), .wdata(bus_wdata),
      .set(fault_set[g]), .q(fault_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mma_q      <= '0;
      bfa_q      <= '0;
      usage_pend <= 1'b0;
    end else begin
      if (mma_wr) mma_q <= bus_wdata;
      if (bfa_wr) bfa_q <= bus_wdata;
      usage_pend <= usage_evt;
    end
  end

  scs_swi_gate #(.NUM_IRQ(NUM_IRQ)) u_swi (
    .clk(clk), .rst_n(rst_n), .wr_hit(swi_wr), .num_in(bus_wdata[SWI_W-1:0]),
    .priv(bus_priv), .user_ok(ccr_q[CCR_USERPEND_BIT]),
    .swi_valid(swi_valid), .swi_num(swi_num)
  );

  always_comb begin
    case (bus_off)
      OFF_CCR: bus_rdata = ccr_q;
      OFF_CFS: bus_rdata = fault_q[0];
      OFF_HFS: bus_rdata = fault_q[1];
      OFF_DFS: bus_rdata = fault_q[2];
      OFF_MMA: bus_rdata = mma_q;
      OFF_BFA: bus_rdata = bfa_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_ccr_rd_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off == OFF_CCR) |-> ((bus_rdata & ~CCR_WMASK) == '0));
  assert_addr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mma_wr |=> (mma_q == $past(bus_wdata)));
  assert_usage_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    usage_evt |=> usage_pend);
  assert_usage_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !usage_evt |=> !usage_pend);
  assert_undef_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_undef |=> fault_q[0][CFS_UNDEF_BIT]);
  assert_reserved_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off == OFF_AUX || bus_off == OFF_SWI) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_scs_fault_regs.sv
module sim_scs_fault_regs;
  localparam int NIRQ = 40;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_off = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic ev_undef = 1'b0, ev_nocp = 1'b0;
  logic [31:0] cfs_set = '0, hfs_set = '0, dfs_set = '0;
  logic swi_valid, usage_pend;
  logic [8:0] swi_num;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scs_fault_regs #(.NUM_IRQ(NIRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
    .ev_undef(ev_undef), .ev_nocp(ev_nocp), .cfs_set(cfs_set),
    .hfs_set(hfs_set), .dfs_set(dfs_set), .swi_valid(swi_valid),
    .swi_num(swi_num), .usage_pend(usage_pend)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] o, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_off = o; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] o, output logic [31:0] d);
    @(negedge clk);
    bus_off = o;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] o, input logic [31:0] exp);
    logic [31:0] v;
    rd(o, v);
    check(req, v, exp);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    logic [11:0] foff [3] = '{12'hD28, 12'hD2C, 12'hD30};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd_chk("R2 ccr", 12'hD14, 32'h200);
    for (int i = 0; i < 3; i++) rd_chk("R2 fault", foff[i], 32'h0);
    rd_chk("R2 mmfar", 12'hD34, 32'h0);
    rd_chk("R2 bfar", 12'hD38, 32'h0);
    check("R2 swi_valid", {31'd0, swi_valid}, 32'h0);
    check("R2 usage_pend", {31'd0, usage_pend}, 32'h0);

    // R1 every single bit of the configuration word
    for (int b = 0; b < 32; b++) begin
      wr(12'hD14, 32'h1 << b);
      rd_chk("R1 ccr bit", 12'hD14, (32'h1 << b) & 32'h31B);
    end
    wr(12'hD14, 32'hFFFF_FFFF);
    rd_chk("R1 ccr all", 12'hD14, 32'h31B);

    // R4 / R3 per fault word: set pattern, clear bit by bit
    for (int r = 0; r < 3; r++) begin
      pat = 32'hA5A5_5A5A ^ (32'h0101_0101 << r);
      @(negedge clk);
      if (r == 0) cfs_set = pat; else if (r == 1) hfs_set = pat; else dfs_set = pat;
      @(negedge clk);
      cfs_set = '0; hfs_set = '0; dfs_set = '0;
      rd_chk("R4 hw set", foff[r], pat);
      wr(foff[r], 32'h0);
      rd_chk("R3 write zero keeps", foff[r], pat);
      for (int b = 0; b < 32; b++) begin
        wr(foff[r], 32'h1 << b);
        pat = pat & ~(32'h1 << b);
        rd_chk("R3 w1c", foff[r], pat);
      end
    end

    // R5 collision: set bit 5, clear all ones
    @(negedge clk);
    cfs_set = 32'h0000_0021;
    @(negedge clk);
    cfs_set = '0;
    @(negedge clk);
    bus_wr = 1'b1; bus_off = 12'hD28; bus_wdata = 32'hFFFF_FFFF; cfs_set = 32'h20;
    @(negedge clk);
    bus_wr = 1'b0; cfs_set = '0;
    rd_chk("R5 set wins", 12'hD28, 32'h20);
    wr(12'hD28, 32'h20);

    // R8 events
    @(negedge clk); ev_undef = 1'b1;
    @(negedge clk); ev_undef = 1'b0;
    check("R8 usage undef", {31'd0, usage_pend}, 32'h1);
    rd_chk("R8 undef bit16", 12'hD28, 32'h0001_0000);
    check("R8 usage drops", {31'd0, usage_pend}, 32'h0);
    wr(12'hD28, 32'hFFFF_FFFF);
    @(negedge clk); ev_nocp = 1'b1;
    @(negedge clk); ev_nocp = 1'b0;
    check("R8 usage nocp", {31'd0, usage_pend}, 32'h1);
    rd_chk("R8 nocp bit19", 12'hD28, 32'h0008_0000);
    @(negedge clk); ev_nocp = 1'b1; ev_undef = 1'b1;
    @(negedge clk); ev_nocp = 1'b0; ev_undef = 1'b0;
    check("R8 usage both", {31'd0, usage_pend}, 32'h1);
    rd_chk("R8 both bits", 12'hD28, 32'h0009_0000);
    wr(12'hD28, 32'hFFFF_FFFF);

    // R6 address words
    wr(12'hD34, 32'hDEAD_BEEF);
    wr(12'hD38, 32'h1234_5678);
    rd_chk("R6 mmfar", 12'hD34, 32'hDEAD_BEEF);
    rd_chk("R6 bfar", 12'hD38, 32'h1234_5678);
    wr(12'hD34, 32'h0F0F_0F0F);
    rd_chk("R6 mmfar rewrite", 12'hD34, 32'h0F0F_0F0F);
    rd_chk("R10 bfar untouched", 12'hD38, 32'h1234_5678);

    // R9 reserved and unmapped offsets
    wr(12'hD3C, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'hD15, 32'hFFFF_FFFF);
    wr(12'hD35, 32'hFFFF_FFFF);
    wr(12'hFFC, 32'hFFFF_FFFF);
    rd_chk("R9 aux", 12'hD3C, 32'h0);
    rd_chk("R9 zero off", 12'h000, 32'h0);
    rd_chk("R9 unaligned", 12'hD15, 32'h0);
    rd_chk("R9 top", 12'hFFC, 32'h0);
    rd_chk("R9 ccr kept", 12'hD14, 32'h31B);
    rd_chk("R9 mmfar kept", 12'hD34, 32'h0F0F_0F0F);
    for (int i = 0; i < 3; i++) rd_chk("R9 fault kept", foff[i], 32'h0);

    // R7 full sweep of the number field
    for (int u = 0; u < 2; u++) begin
      wr(12'hD14, 32'h200 | (u << 1));
      for (int p = 0; p < 2; p++) begin
        bus_priv = p[0];
        for (int n = 0; n < 512; n++) begin
          logic exp_ok;
          exp_ok = (n < NIRQ) && (p == 1 || u == 1);
          wr(12'hF00, 32'hABCD_E000 | n);
          check("R7 swi_valid", {31'd0, swi_valid}, {31'd0, exp_ok});
          if (exp_ok) check("R7 swi_num", {23'd0, swi_num}, n);
        end
      end
    end
    bus_priv = 1'b1;
    wr(12'hF00, NIRQ - 1);
    @(negedge clk);
    check("R7 one cycle pulse", {31'd0, swi_valid}, 32'h0);
    rd_chk("R9 trigger reads zero", 12'hF00, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule